// File: doc/BRIEF.md
# D-PHY Power-Up Register Sequencer

This block brings a multi-lane MIPI D-PHY transmitter out of reset when it sees a start pulse. It drives a write-only valid/ready register bus. Each write carries an address, a data word and a per-bit write mask. The register target merges every write: bits under the mask take the new data, and all other bits keep their old value. The sequence opens the lanes in use. It then pulses the analog reset, which is active high, and after that the digital reset, which is active low. Each pulse is held for a minimum number of system clock cycles. Finally the block hands each active lane in turn to an external timing engine, which programs that lane's timing.

The timing engine sees a request with a lane select. The request stays high until the engine answers with a one-cycle acknowledge. Data lanes are handed over from the highest index in use down to lane 0, and the clock lane comes last. After a final settle time the block raises a one-cycle done pulse. While the block is idle, a stop pulse closes the lanes again with a single masked write. Wait times are counted in clock cycles, from a parameter that gives the number of clock cycles per microsecond.

Top module: `dps_pwrup_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wr_valid` and `lane_req` are all low.
- R2: The first write of a start sequence goes to address 0x000 with mask 0x7C. Its data is 0x44, 0x4C, 0x5C or 0x7C for 1, 2, 3 or 4 lanes. Bit 2+i enables data lane i and bit 6 enables the clock lane. A `lane_cfg` of 0 (unconfigured) or above 4 means 4 lanes. The lane count is captured when start is taken, so later changes to `lane_cfg` have no effect on that run.
- R3: The second write goes to address 0x004 with mask 0x004 and data 0x004, which sets the analog reset. At least `CYC_PER_US*RST_HOLD_US` cycles after that write is accepted, the third write goes to the same address and mask with data 0.
- R4: Only after the analog reset is cleared, the fourth write goes to address 0x080 with mask 0x001 and data 0. At least the same hold time later, the fifth write sets data 0x001.
- R5: After the fifth write, `lane_req` steps through `lane_sel` values n-1 down to 0, then 4 for the clock lane. Each request is held, with `lane_sel` stable, until `lane_ack` arrives.
- R6: `busy` rises the cycle after an accepted start. `done` is a one-cycle pulse that comes at least `CYC_PER_US*SETTLE_US` cycles after the clock lane's acknowledge. `busy` is low after `done`.
- R7: A start or stop pulse that arrives while `busy` is high is ignored: no extra write, lane request or done pulse follows.
- R8: A stop pulse while idle issues exactly one write, to address 0x000 with mask 0x7C and data 0. No lane request and no done pulse follow it.
- R9: `wr_valid` stays high, with address, data and mask unchanged, until `wr_ready` is seen. Data bits outside the mask are zero, so bits of the target registers outside the mask are preserved.
- R10: At most one of `wr_valid`, `lane_req` and `done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start the power-up sequence (taken only when idle) |
| stop | input | 1 | Close all lanes (taken only when idle) |
| lane_cfg | input | 3 | Configured lane count; 0 or above 4 means 4 |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of power-up |
| wr_valid | output | 1 | Register write request valid |
| wr_ready | input | 1 | Register target accepts the write |
| wr_addr | output | 12 | Register byte address |
| wr_data | output | 32 | Write data |
| wr_mask | output | 32 | Per-bit write mask |
| lane_req | output | 1 | Ask the timing engine to program a lane |
| lane_sel | output | 3 | Lane to program: 0 to 3 data lane, 4 clock lane |
| lane_ack | input | 1 | Timing engine finished the selected lane |

## Verification
The bench sweeps all eight `lane_cfg` codes under two bus conditions: a target that is always ready, and one that stalls every third cycle. This separates the four lane-enable values and the out-of-range defaults. It also shows whether the payload and the reset hold windows survive back-pressure. In every run the bench changes `lane_cfg` right after start, which shows whether the lane count was captured at start. In one run per bus condition, start and stop are pulsed mid-sequence to show that they are ignored while busy. A preset target register model, with bits set outside the fields, shows whether the masked writes leave neighbouring bits intact. A stop from idle is checked on its own: one write and no lane activity.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int unsigned BUS_AW     = 12;
    localparam int unsigned BUS_DW     = 32;
    localparam int unsigned MAX_LANES  = 4;
    localparam int unsigned LANE_CNT_W = 3;
    localparam int unsigned LANE_SEL_W = 3;

    // register map used by the sequence
    localparam logic [BUS_AW-1:0] ADDR_LANE = 12'h000;
    localparam logic [BUS_AW-1:0] ADDR_PWR  = 12'h004;
    localparam logic [BUS_AW-1:0] ADDR_DIG  = 12'h080;

    // lane field: data lane i at bit LANE_LSB+i, clock lane just above
    localparam int unsigned LANE_LSB    = 2;
    localparam int unsigned CLK_EN_BIT  = LANE_LSB + MAX_LANES;
    localparam logic [BUS_DW-1:0] LANE_FIELD_MASK =
        BUS_DW'(((1 << (MAX_LANES + 1)) - 1) << LANE_LSB);

    localparam int unsigned ARST_BIT = 2;   // active high
    localparam int unsigned DRST_BIT = 0;   // active low
    localparam logic [BUS_DW-1:0] ARST_MASK = BUS_DW'(1) << ARST_BIT;
    localparam logic [BUS_DW-1:0] DRST_MASK = BUS_DW'(1) << DRST_BIT;

    localparam logic [LANE_SEL_W-1:0] CLK_LANE_SEL = LANE_SEL_W'(MAX_LANES);

    typedef enum logic [3:0] {
        S_IDLE,
        S_LANE_ON,
        S_ARST_SET,
        S_ARST_HOLD,
        S_ARST_CLR,
        S_DRST_SET,
        S_DRST_HOLD,
        S_DRST_CLR,
        S_LANE_PROG,
        S_SETTLE,
        S_FINISH,
        S_LANE_OFF
    } seq_state_e;

    typedef struct packed {
        logic [BUS_AW-1:0] addr;
        logic [BUS_DW-1:0] data;
        logic [BUS_DW-1:0] mask;
    } wr_req_t;

    typedef struct packed {
        seq_state_e             st;
        logic [LANE_CNT_W-1:0]  lanes;
        logic [BUS_DW-1:0]      field;
        logic [LANE_SEL_W-1:0]  idx;
    } seq_regs_t;

endpackage

// File: rtl/dps_lane_decode.sv
module dps_lane_decode
    import dps_pkg::*;
(
    input  logic [LANE_CNT_W-1:0] cfg,
    output logic [LANE_CNT_W-1:0] count,
    output logic [BUS_DW-1:0]     field
);

    logic [MAX_LANES-1:0] lane_en;

    always_comb begin
        if (cfg == '0 || cfg > LANE_CNT_W'(MAX_LANES)) begin
            count = LANE_CNT_W'(MAX_LANES);
        end else begin
            count = cfg;
        end
    end

    generate
        for (genvar i = 0; i < int'(MAX_LANES); i++) begin : g_lane_en
            assign lane_en[i] = (LANE_CNT_W'(i) < count);
        end
    endgenerate

    always_comb begin
        field                          = '0;
        field[LANE_LSB +: MAX_LANES]   = lane_en;
        field[CLK_EN_BIT]              = 1'b1;
    end

endmodule

// File: rtl/dps_wait_timer.sv
module dps_wait_timer #(
    parameter int unsigned TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && (cnt_q == LAST);

endmodule

// File: rtl/dps_wr_port.sv
module dps_wr_port
    import dps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  wr_req_t           req_pkt,
    output logic              accepted,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [BUS_AW-1:0] wr_addr,
    output logic [BUS_DW-1:0] wr_data,
    output logic [BUS_DW-1:0] wr_mask
);

    logic    vld_d, vld_q;
    wr_req_t pkt_d, pkt_q;

    always_comb begin
        vld_d = vld_q;
        pkt_d = pkt_q;
        if (vld_q && wr_ready) begin
            vld_d = 1'b0;
        end else if (!vld_q && req) begin
            vld_d = 1'b1;
            pkt_d = req_pkt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            pkt_q <= '0;
        end else begin
            vld_q <= vld_d;
            pkt_q <= pkt_d;
        end
    end

    assign accepted = vld_q && wr_ready;
    assign wr_valid = vld_q;
    assign wr_addr  = pkt_q.addr;
    assign wr_data  = pkt_q.data;
    assign wr_mask  = pkt_q.mask;

endmodule

// File: rtl/dps_pwrup_seq.sv
module dps_pwrup_seq
    import dps_pkg::*;
#(
    parameter int unsigned CYC_PER_US  = 100,
    parameter int unsigned RST_HOLD_US = 1,
    parameter int unsigned SETTLE_US   = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  stop,
    input  logic [LANE_CNT_W-1:0] lane_cfg,
    output logic                  busy,
    output logic                  done,
    output logic                  wr_valid,
    input  logic                  wr_ready,
    output logic [BUS_AW-1:0]     wr_addr,
    output logic [BUS_DW-1:0]     wr_data,
    output logic [BUS_DW-1:0]     wr_mask,
    output logic                  lane_req,
    output logic [LANE_SEL_W-1:0] lane_sel,
    input  logic                  lane_ack
);

    localparam int unsigned HOLD_RAW   = CYC_PER_US * RST_HOLD_US;
    localparam int unsigned SETTLE_RAW = CYC_PER_US * SETTLE_US;
    localparam int unsigned HOLD_CYC   = (HOLD_RAW   > 0) ? HOLD_RAW   : 1;
    localparam int unsigned SETTLE_CYC = (SETTLE_RAW > 0) ? SETTLE_RAW : 1;

    localparam seq_regs_t SEQ_RST = '{st: S_IDLE, lanes: '0, field: '0, idx: '0};

    seq_regs_t r_d, r_q;

    logic [LANE_CNT_W-1:0] dec_count;
    logic [BUS_DW-1:0]     dec_field;
    logic                  hold_run, hold_exp;
    logic                  settle_run, settle_exp;
    logic                  wr_req, wr_acc;
    wr_req_t               wr_pkt;

    dps_lane_decode u_dec (
        .cfg   (lane_cfg),
        .count (dec_count),
        .field (dec_field)
    );

    dps_wait_timer #(.TICKS(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_run),
        .expired (hold_exp)
    );

    dps_wait_timer #(.TICKS(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (settle_run),
        .expired (settle_exp)
    );

    dps_wr_port u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (wr_req),
        .req_pkt  (wr_pkt),
        .accepted (wr_acc),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask)
    );

    assign hold_run   = (r_q.st == S_ARST_HOLD) || (r_q.st == S_DRST_HOLD);
    assign settle_run = (r_q.st == S_SETTLE);

    // write request for the current state
    always_comb begin
        wr_req = 1'b1;
        wr_pkt = '0;
        unique case (r_q.st)
            S_LANE_ON: begin
                wr_pkt.addr = ADDR_LANE;
                wr_pkt.data = r_q.field & LANE_FIELD_MASK;
                wr_pkt.mask = LANE_FIELD_MASK;
            end
            S_ARST_SET: begin
                wr_pkt.addr = ADDR_PWR;
                wr_pkt.data = ARST_MASK;
                wr_pkt.mask = ARST_MASK;
            end
            S_ARST_CLR: begin
                wr_pkt.addr = ADDR_PWR;
                wr_pkt.data = '0;
                wr_pkt.mask = ARST_MASK;
            end
            S_DRST_SET: begin
                wr_pkt.addr = ADDR_DIG;
                wr_pkt.data = '0;
                wr_pkt.mask = DRST_MASK;
            end
            S_DRST_CLR: begin
                wr_pkt.addr = ADDR_DIG;
                wr_pkt.data = DRST_MASK;
                wr_pkt.mask = DRST_MASK;
            end
            S_LANE_OFF: begin
                wr_pkt.addr = ADDR_LANE;
                wr_pkt.data = '0;
                wr_pkt.mask = LANE_FIELD_MASK;
            end
            default: wr_req = 1'b0;
        endcase
    end

    // sequence next state
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    r_d.st    = S_LANE_ON;
                    r_d.lanes = dec_count;
                    r_d.field = dec_field;
                end else if (stop) begin
                    r_d.st = S_LANE_OFF;
                end
            end
            S_LANE_ON:   if (wr_acc)   r_d.st = S_ARST_SET;
            S_ARST_SET:  if (wr_acc)   r_d.st = S_ARST_HOLD;
            S_ARST_HOLD: if (hold_exp) r_d.st = S_ARST_CLR;
            S_ARST_CLR:  if (wr_acc)   r_d.st = S_DRST_SET;
            S_DRST_SET:  if (wr_acc)   r_d.st = S_DRST_HOLD;
            S_DRST_HOLD: if (hold_exp) r_d.st = S_DRST_CLR;
            S_DRST_CLR: begin
                if (wr_acc) begin
                    r_d.st  = S_LANE_PROG;
                    r_d.idx = LANE_SEL_W'(r_q.lanes - 1'b1);
                end
            end
            S_LANE_PROG: begin
                if (lane_ack) begin
                    if (r_q.idx == CLK_LANE_SEL) begin
                        r_d.st = S_SETTLE;
                    end else if (r_q.idx == '0) begin
                        r_d.idx = CLK_LANE_SEL;
                    end else begin
                        r_d.idx = r_q.idx - 1'b1;
                    end
                end
            end
            S_SETTLE:   if (settle_exp) r_d.st = S_FINISH;
            S_FINISH:   r_d.st = S_IDLE;
            S_LANE_OFF: if (wr_acc)     r_d.st = S_IDLE;
            default:    r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= SEQ_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != S_IDLE);
    assign done     = (r_q.st == S_FINISH);
    assign lane_req = (r_q.st == S_LANE_PROG);
    assign lane_sel = r_q.idx;

endmodule

// File: rtl/dps_seq_chk.sv
module dps_seq_chk
    import dps_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  busy,
    input logic                  done,
    input logic                  wr_valid,
    input logic                  wr_ready,
    input logic [BUS_AW-1:0]     wr_addr,
    input logic [BUS_DW-1:0]     wr_data,
    input logic [BUS_DW-1:0]     wr_mask,
    input logic                  lane_req,
    input logic [LANE_SEL_W-1:0] lane_sel,
    input logic                  lane_ack
);

    // R9
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> wr_valid);

    // R9
    payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> ($stable(wr_addr) && $stable(wr_data) && $stable(wr_mask)));

    // R9
    data_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_data & ~wr_mask) == '0));

    // R10
    one_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_valid, lane_req, done}));

    // R5
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_req && !lane_ack) |=> (lane_req && $stable(lane_sel)));

    // R5
    lane_sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_req |-> (lane_sel <= CLK_LANE_SEL));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R6
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

endmodule

bind dps_pwrup_seq dps_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_mask  (wr_mask),
    .lane_req (lane_req),
    .lane_sel (lane_sel),
    .lane_ack (lane_ack)
);

// File: tb/dps_pwrup_seq_test.sv
`timescale 1ns/1ps
module dps_pwrup_seq_test;

    localparam int CPU  = 8;
    localparam int HOLD = CPU;
    localparam int SETL = CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [2:0]  lane_cfg = 3'd0;
    logic        busy, done, wr_valid, lane_req;
    logic        wr_ready = 1'b0;
    logic        lane_ack = 1'b0;
    logic [11:0] wr_addr;
    logic [31:0] wr_data, wr_mask;
    logic [2:0]  lane_sel;

    dps_pwrup_seq #(.CYC_PER_US(CPU), .RST_HOLD_US(1), .SETTLE_US(1)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .lane_cfg(lane_cfg),
        .busy(busy), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
        .lane_req(lane_req), .lane_sel(lane_sel), .lane_ack(lane_ack)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0;
    int n_fail  = 0;

    // logs and target register model
    logic [11:0] wl_addr [0:15];
    logic [31:0] wl_data [0:15];
    logic [31:0] wl_mask [0:15];
    int          wl_cyc  [0:15];
    int          wl_n = 0;
    logic [2:0]  ll_sel  [0:15];
    int          ll_cyc  [0:15];
    int          ll_n = 0;
    int          first_lreq = -1;
    int          done_n = 0;
    int          done_cyc = 0;
    int          ack_dly = 0;
    int          rdy_mode = 0;
    logic [31:0] rf_lane = 32'h0;
    logic [31:0] rf_pwr  = 32'h0;
    logic [31:0] rf_dig  = 32'h0;

    always @(negedge clk) begin
        logic rdy;
        rdy = rst_n && (rdy_mode == 0 || (cyc % 3) != 0);
        wr_ready = rdy;
        if (wr_valid && rdy) begin
            if (wl_n < 16) begin
                wl_addr[wl_n] = wr_addr;
                wl_data[wl_n] = wr_data;
                wl_mask[wl_n] = wr_mask;
                wl_cyc[wl_n]  = cyc;
            end
            wl_n = wl_n + 1;
            case (wr_addr)
                12'h000: rf_lane = (rf_lane & ~wr_mask) | (wr_data & wr_mask);
                12'h004: rf_pwr  = (rf_pwr  & ~wr_mask) | (wr_data & wr_mask);
                12'h080: rf_dig  = (rf_dig  & ~wr_mask) | (wr_data & wr_mask);
                default: ;
            endcase
        end
        if (lane_ack) begin
            lane_ack = 1'b0;
            ack_dly  = 0;
        end else if (lane_req) begin
            if (first_lreq < 0) first_lreq = cyc;
            ack_dly = ack_dly + 1;
            if (ack_dly >= 2) begin
                lane_ack = 1'b1;
                if (ll_n < 16) begin
                    ll_sel[ll_n] = lane_sel;
                    ll_cyc[ll_n] = cyc;
                end
                ll_n = ll_n + 1;
            end
        end
        if (done) begin
            done_n   = done_n + 1;
            done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        wl_n = 0; ll_n = 0; first_lreq = -1; done_n = 0; done_cyc = 0;
    endtask

    function automatic int lanes_of(input int cfg);
        return (cfg >= 1 && cfg <= 4) ? cfg : 4;
    endfunction

    function automatic logic [31:0] field_of(input int n);
        return 32'h40 | ((32'(1) << n) - 1) << 2;
    endfunction

    task automatic run_seq(input int cfg, input int mode, input bit inject);
        int n;
        logic [31:0] fld;
        logic [31:0] pre_lane, pre_pwr, pre_dig;
        int wait_n;
        n   = lanes_of(cfg);
        fld = field_of(n);
        @(negedge clk);
        rdy_mode = mode;
        clear_logs();
        pre_lane = 32'hA5A5_A583;
        pre_pwr  = 32'h0F0F_0F0B;
        pre_dig  = 32'hF0F0_F0F0;
        rf_lane = pre_lane; rf_pwr = pre_pwr; rf_dig = pre_dig;
        lane_cfg = 3'(cfg);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lane_cfg = 3'(cfg) ^ 3'd5;   // R2: changes after start are ignored
        chk(busy == 1'b1, "R6", "busy after start", 32'(busy), 32'd1);
        if (inject) begin
            repeat (15) @(negedge clk);
            start = 1'b1; stop = 1'b1;
            @(negedge clk);
            start = 1'b0; stop = 1'b0;
        end
        wait_n = 0;
        while (done_n == 0 && wait_n < 5000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(wait_n < 5000, "R6", "watchdog done", 32'(wait_n), 32'd0);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R6", "busy after done", 32'(busy), 32'd0);
        chk(done_n == 1, inject ? "R7" : "R6", "done count", 32'(done_n), 32'd1);
        chk(wl_n == 5, inject ? "R7" : "R2", "write count", 32'(wl_n), 32'd5);
        if (wl_n >= 5) begin
            chk(wl_addr[0] == 12'h000 && wl_mask[0] == 32'h7C && wl_data[0] == fld,
                "R2", "lane enable data", wl_data[0], fld);
            chk(wl_addr[1] == 12'h004 && wl_mask[1] == 32'h4 && wl_data[1] == 32'h4,
                "R3", "analog set", wl_data[1], 32'h4);
            chk(wl_addr[2] == 12'h004 && wl_mask[2] == 32'h4 && wl_data[2] == 32'h0,
                "R3", "analog clear", wl_data[2], 32'h0);
            chk(wl_cyc[2] - wl_cyc[1] >= HOLD, "R3", "analog hold cycles",
                32'(wl_cyc[2] - wl_cyc[1]), 32'(HOLD));
            chk(wl_addr[3] == 12'h080 && wl_mask[3] == 32'h1 && wl_data[3] == 32'h0,
                "R4", "digital assert", wl_data[3], 32'h0);
            chk(wl_addr[4] == 12'h080 && wl_mask[4] == 32'h1 && wl_data[4] == 32'h1,
                "R4", "digital release", wl_data[4], 32'h1);
            chk(wl_cyc[4] - wl_cyc[3] >= HOLD, "R4", "digital hold cycles",
                32'(wl_cyc[4] - wl_cyc[3]), 32'(HOLD));
            chk(first_lreq > wl_cyc[4], "R5", "lanes after resets",
                32'(first_lreq), 32'(wl_cyc[4]));
        end
        chk(rf_lane == ((pre_lane & ~32'h7C) | fld), "R9", "lane reg merge",
            rf_lane, (pre_lane & ~32'h7C) | fld);
        chk(rf_pwr == (pre_pwr & ~32'h4), "R9", "power reg merge", rf_pwr, pre_pwr & ~32'h4);
        chk(rf_dig == (pre_dig | 32'h1), "R9", "digital reg merge", rf_dig, pre_dig | 32'h1);
        chk(ll_n == n + 1, "R5", "lane request count", 32'(ll_n), 32'(n + 1));
        if (ll_n == n + 1) begin
            for (int k = 0; k <= n; k++) begin
                logic [2:0] exp_sel;
                exp_sel = (k == n) ? 3'd4 : 3'(n - 1 - k);
                chk(ll_sel[k] == exp_sel, "R5", "lane order", 32'(ll_sel[k]), 32'(exp_sel));
            end
            chk(done_cyc - ll_cyc[n] >= SETL, "R6", "settle cycles",
                32'(done_cyc - ll_cyc[n]), 32'(SETL));
        end
    endtask

    task automatic run_stop();
        logic [31:0] pre_lane;
        @(negedge clk);
        clear_logs();
        pre_lane = 32'h1234_56FF;
        rf_lane  = pre_lane;
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk(busy == 1'b1, "R8", "busy during stop", 32'(busy), 32'd1);
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R8", "idle after stop", 32'(busy), 32'd0);
        chk(wl_n == 1, "R8", "stop write count", 32'(wl_n), 32'd1);
        if (wl_n == 1) begin
            chk(wl_addr[0] == 12'h000 && wl_mask[0] == 32'h7C && wl_data[0] == 32'h0,
                "R8", "stop write", wl_data[0], 32'h0);
        end
        chk(rf_lane == (pre_lane & ~32'h7C), "R8", "lane field cleared",
            rf_lane, pre_lane & ~32'h7C);
        chk(ll_n == 0 && done_n == 0, "R8", "no lane or done after stop",
            32'(ll_n + done_n), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && wr_valid == 0 && lane_req == 0,
            "R1", "reset outputs", {28'd0, busy, done, wr_valid, lane_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && done == 0 && wr_valid == 0 && lane_req == 0,
            "R1", "idle after reset", {28'd0, busy, done, wr_valid, lane_req}, 32'd0);
        for (int mode = 0; mode < 2; mode++) begin
            for (int cfg = 0; cfg < 8; cfg++) begin
                run_seq(cfg, mode, cfg == 3);
            end
            run_stop();
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule